// File: doc/BRIEF.md
# Single-Cycle Word-Addressed 32-bit Processor Core

This block is a compact processor core that completes one instruction on every clock. In each cycle it presents the program counter to an external instruction store and decodes the returned 32-bit word at once. In that same cycle it commits the result to its sixteen-entry register file or to the data store and chooses the next program counter. Both stores are addressed in 32-bit words, and every address leaving the core is sixteen bits wide.

The core is a two-state machine. After reset it is in `ST_RUN`, with the program counter and all registers cleared. In `ST_RUN` one instruction retires per clock. The stop instruction moves it to `ST_STOPPED` (transition RUN_TO_STOPPED). In that state nothing retires, the program counter holds the address of the stop instruction, and `halted` is high. The only way out is reset (transition STOPPED_TO_RUN).

Top module: `wc_core`

## Requirements
- R1: While reset is low and right after it is released, `halted` is 0 and `imem_addr` is 0. Reset clears every register, so a rerun of the same program gives the same results.
- R2: Fields: opcode [31:28], target/store register T [27:24], base/source register S [23:20], second source [3:0], immediate [19:0] sign-extended to 32 bits. Opcode 0 writes S plus second source into T. Opcode 1 writes the bitwise NAND of S and second source into T. Opcode 2 writes S plus the immediate into T.
- R3: Register 0 always reads as zero, and a write to it has no effect.
- R4: Opcode 3 loads the data word at S plus the immediate into T. Opcode 4 stores register T to that word address. Addresses count 32-bit words.
- R5: Only the low 16 bits of a computed data address reach `dmem_addr`. Upper bits are dropped.
- R6: Opcode 5 branches when T >= S, and opcode 8 branches when T <= S. Both compare as signed two's-complement values and both branch on equality. The target is the address of the branch plus one plus the immediate, and negative immediates branch backwards.
- R7: Opcode 6 writes the address of the jump plus one into T and continues at the value S held before that write. This holds even when T and S name the same register.
- R8: Opcode 9 writes the address of the instruction plus one plus the immediate into T, without a data access.
- R9: Opcode 7 enters `ST_STOPPED`. After that, `halted` stays 1, `imem_addr` stays at the address of the stop instruction, and `dmem_we` stays 0 until reset.
- R10: Opcodes 10 to 15 change no register and no memory, and only advance the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Word address of the instruction being executed |
| imem_data | input | 32 | Instruction word, valid in the same cycle as its address |
| dmem_addr | output | 16 | Word address for a load or a store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, sampled by the data store on the rising edge |
| dmem_rdata | input | 32 | Load data, valid combinationally for `dmem_addr` |
| halted | output | 1 | High in `ST_STOPPED` |

## Verification
The jump-and-link instruction reads a register and writes that same register in one cycle. The jump must use the old value while the link overwrites it.

The bench provokes this by loading a target into one register and issuing a jump that names that register as both link and target. A store placed at the target and a skipped store right after the jump show which way control went. The register is then stored to memory to show that it ended up holding the link address.

A second case shares a cycle as well: a backward branch retires in the same clock as the counter update it guards. A loop whose iteration count is stored after the loop judges that case.

// File: rtl/wc_pkg.sv
package wc_pkg;

    localparam int XLEN = 32;
    localparam int AW   = 16;
    localparam int NREG = 16;
    localparam int RIDX = $clog2(NREG);
    localparam int IMMW = 20;
    localparam int OPW  = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_NAND = 4'd1,
        OP_ADDI = 4'd2,
        OP_LW   = 4'd3,
        OP_SW   = 4'd4,
        OP_BGE  = 4'd5,
        OP_JALR = 4'd6,
        OP_HALT = 4'd7,
        OP_BLE  = 4'd8,
        OP_LEA  = 4'd9
    } opcode_e;

    typedef enum logic [1:0] {
        WB_ALU,
        WB_MEM,
        WB_LINK
    } wb_sel_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_NAND,
        ALU_PCREL
    } alu_op_e;

    typedef enum logic {
        ST_RUN,
        ST_STOPPED
    } core_state_e;

    typedef struct packed {
        logic    rf_we;
        wb_sel_e wb;
        logic    mem_we;
        logic    b_from_t;
        logic    use_imm;
        alu_op_e alu;
        logic    br_ge;
        logic    br_le;
        logic    jump;
        logic    stop;
        logic    undef;
    } ctl_t;

endpackage

// File: rtl/wc_regfile.sv
module wc_regfile
    import wc_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] raddr_a,
    input  logic [$clog2(N)-1:0] raddr_b,
    output logic [W-1:0]         rdata_a,
    output logic [W-1:0]         rdata_b,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata
);

    localparam int IW = $clog2(N);

    logic [N-1:0][W-1:0] regs;

    // entry 0 has no storage at all
    assign regs[0] = '0;

    for (genvar g = 1; g < N; g++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == IW'(g))) begin
                q <= wdata;
            end
        end
        assign regs[g] = q;
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/wc_decode.sv
module wc_decode
    import wc_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output ctl_t           ctl
);

    always_comb begin
        ctl     = '0;
        ctl.wb  = WB_ALU;
        ctl.alu = ALU_ADD;
        unique case (opcode_e'(opcode))
            OP_ADD: begin
                ctl.rf_we = 1'b1;
            end
            OP_NAND: begin
                ctl.rf_we = 1'b1;
                ctl.alu   = ALU_NAND;
            end
            OP_ADDI: begin
                ctl.rf_we   = 1'b1;
                ctl.use_imm = 1'b1;
            end
            OP_LW: begin
                ctl.rf_we = 1'b1;
                ctl.wb    = WB_MEM;
            end
            OP_SW: begin
                ctl.mem_we   = 1'b1;
                ctl.b_from_t = 1'b1;
            end
            OP_BGE: begin
                ctl.br_ge    = 1'b1;
                ctl.b_from_t = 1'b1;
            end
            OP_BLE: begin
                ctl.br_le    = 1'b1;
                ctl.b_from_t = 1'b1;
            end
            OP_JALR: begin
                ctl.rf_we = 1'b1;
                ctl.wb    = WB_LINK;
                ctl.jump  = 1'b1;
            end
            OP_HALT: begin
                ctl.stop = 1'b1;
            end
            OP_LEA: begin
                ctl.rf_we = 1'b1;
                ctl.alu   = ALU_PCREL;
            end
            default: begin
                ctl.undef = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wc_execute.sv
module wc_execute
    import wc_pkg::*;
#(
    parameter int W = XLEN,
    parameter int A = AW
) (
    input  ctl_t         ctl,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] src_s,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] imm,
    output logic [W-1:0] alu_res,
    output logic [W-1:0] pc_inc,
    output logic [W-1:0] pc_next,
    output logic [A-1:0] mem_addr,
    output logic         br_taken
);

    logic t_ge_s;
    logic t_le_s;

    assign pc_inc   = pc + W'(1);
    // only A bits leave the core, so only A bits are summed
    assign mem_addr = src_s[A-1:0] + imm[A-1:0];

    always_comb begin
        unique case (ctl.alu)
            ALU_ADD:   alu_res = ctl.use_imm ? (src_s + imm) : (src_s + src_b);
            ALU_NAND:  alu_res = ~(src_s & src_b);
            ALU_PCREL: alu_res = pc_inc + imm;
            default:   alu_res = '0;
        endcase
    end

    // src_b carries register T for branches
    assign t_ge_s   = $signed(src_b) >= $signed(src_s);
    assign t_le_s   = $signed(src_b) <= $signed(src_s);
    assign br_taken = (ctl.br_ge && t_ge_s) || (ctl.br_le && t_le_s);

    always_comb begin
        if (ctl.jump) begin
            pc_next = src_s;
        end else if (br_taken) begin
            pc_next = pc_inc + imm;
        end else begin
            pc_next = pc_inc;
        end
    end

endmodule

// File: rtl/wc_core.sv
module wc_core
    import wc_pkg::*;
#(
    parameter int W = XLEN,
    parameter int A = AW
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [A-1:0] imem_addr,
    input  logic [W-1:0] imem_data,
    output logic [A-1:0] dmem_addr,
    output logic [W-1:0] dmem_wdata,
    output logic         dmem_we,
    input  logic [W-1:0] dmem_rdata,
    output logic         halted
);

    core_state_e state_q, state_d;
    logic [W-1:0] pc_q, pc_d;

    ctl_t            ctl;
    logic [RIDX-1:0] f_t, f_s, f_b, rb_addr;
    logic [W-1:0]    imm_ext;
    logic [W-1:0]    rd_s, rd_b, alu_res, pc_inc, pc_next, wb_data;
    logic            br_taken, commit, rf_we;

    assign f_t     = imem_data[27:24];
    assign f_s     = imem_data[23:20];
    assign f_b     = imem_data[3:0];
    assign imm_ext = {{(W-IMMW){imem_data[IMMW-1]}}, imem_data[IMMW-1:0]};
    assign rb_addr = ctl.b_from_t ? f_t : f_b;

    wc_decode u_decode (
        .opcode (imem_data[W-1 -: OPW]),
        .ctl    (ctl)
    );

    wc_regfile #(.W(W), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (f_s),
        .raddr_b (rb_addr),
        .rdata_a (rd_s),
        .rdata_b (rd_b),
        .we      (rf_we),
        .waddr   (f_t),
        .wdata   (wb_data)
    );

    wc_execute #(.W(W), .A(A)) u_exec (
        .ctl      (ctl),
        .pc       (pc_q),
        .src_s    (rd_s),
        .src_b    (rd_b),
        .imm      (imm_ext),
        .alu_res  (alu_res),
        .pc_inc   (pc_inc),
        .pc_next  (pc_next),
        .mem_addr (dmem_addr),
        .br_taken (br_taken)
    );

    always_comb begin
        unique case (ctl.wb)
            WB_MEM:  wb_data = dmem_rdata;
            WB_LINK: wb_data = pc_inc;
            default: wb_data = alu_res;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // next-state and output process
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        commit  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (ctl.stop) begin
                    state_d = ST_STOPPED;
                end else begin
                    commit = 1'b1;
                    pc_d   = pc_next;
                end
            end
            ST_STOPPED: begin
                commit = 1'b0;
            end
            default: begin
                state_d = ST_STOPPED;
            end
        endcase
    end

    assign rf_we      = commit && ctl.rf_we;
    assign dmem_we    = commit && ctl.mem_we;
    assign dmem_wdata = rd_b;
    assign imem_addr  = pc_q[A-1:0];
    assign halted     = (state_q == ST_STOPPED);

    // R3
    zero_reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_s == '0) |-> (rd_s == '0));

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_q)));

    // R9
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!dmem_we && !rf_we));

    // R6
    branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && br_taken) |=> (pc_q == $past(pc_q) + W'(1) + $past(imm_ext)));

    // R10
    undef_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctl.undef) |-> (!rf_we && !dmem_we));

    // R10
    undef_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctl.undef) |=> (pc_q == $past(pc_q) + W'(1)));

endmodule

// File: tb/test_wc_core.sv
module test_wc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, dmem_addr;
    logic [31:0] imem_data, dmem_wdata, dmem_rdata;
    logic        dmem_we, halted;

    logic [31:0] imem [64];
    logic [31:0] dmem [256];
    int n_tests = 0;
    int n_fail  = 0;
    int stray_wr = 0;
    int stop_wr  = 0;

    always #4 clk = ~clk;

    wc_core i_wc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .halted     (halted)
    );

    assign imem_data  = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[7:0]];

    always @(posedge clk) begin
        if (dmem_we) begin
            dmem[dmem_addr[7:0]] = dmem_wdata;
            if (dmem_addr[15:8] != 8'h00) stray_wr++;
            if (halted) stop_wr++;
        end
    end

    localparam int NCHK = 15;
    localparam logic [7:0]  CHK_ADDR [NCHK] = '{8'd16, 8'd17, 8'd18, 8'd19, 8'd20,
        8'd21, 8'd22, 8'd23, 8'd24, 8'd25, 8'd26, 8'd27, 8'd28, 8'd29, 8'd30};
    localparam logic [31:0] CHK_VAL  [NCHK] = '{32'd4, 32'hFFFF_FFF8, 32'd0,
        32'h1234_5678, 32'd7, 32'd7, 32'h5555, 32'h5555, 32'h5555, 32'd25,
        32'h5555, 32'd25, 32'd3, 32'd7, 32'h5555};
    // tags: R2 R2 R3 R4 R5 R6 R6 R6 R6 R8 R7 R7 R6 R10 R9
    localparam logic [23:0] CHK_TAG  [NCHK] = '{" R2", " R2", " R3", " R4", " R5",
        " R6", " R6", " R6", " R6", " R8", " R7", " R7", " R6", "R10", " R9"};

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] t,
                                        input logic [3:0] s, input int imm);
        logic [31:0] v;
        v = imm;
        return {op, t, s, v[19:0]};
    endfunction

    task automatic chk(input logic [23:0] tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) dmem[i] = 32'd0;
        dmem[18] = 32'hDEAD;
        dmem[40] = 32'h1234_5678;
        dmem[41] = 32'hABCD_0014;
        dmem[22] = 32'h5555;
        dmem[23] = 32'h5555;
        dmem[24] = 32'h5555;
        dmem[26] = 32'h5555;
        dmem[30] = 32'h5555;
    endtask

    task automatic load_prog();
        for (int i = 0; i < 64; i++) imem[i] = enc(4'd7, 0, 0, 0);
        imem[0]  = enc(4'd2, 3, 0, 7);
        imem[1]  = enc(4'd2, 4, 0, -3);
        imem[2]  = enc(4'd0, 5, 3, 4);
        imem[3]  = enc(4'd1, 6, 3, 3);
        imem[4]  = enc(4'd2, 0, 0, 55);
        imem[5]  = enc(4'd4, 5, 0, 16);
        imem[6]  = enc(4'd4, 6, 0, 17);
        imem[7]  = enc(4'd4, 0, 0, 18);
        imem[8]  = enc(4'd3, 7, 0, 40);
        imem[9]  = enc(4'd4, 7, 0, 19);
        imem[10] = enc(4'd2, 1, 1, 0);
        imem[11] = enc(4'd3, 8, 0, 41);
        imem[12] = enc(4'd4, 3, 8, 0);
        imem[13] = enc(4'd5, 4, 3, 1);
        imem[14] = enc(4'd4, 3, 0, 21);
        imem[15] = enc(4'd8, 4, 3, 1);
        imem[16] = enc(4'd4, 3, 0, 22);
        imem[17] = enc(4'd5, 3, 3, 1);
        imem[18] = enc(4'd4, 3, 0, 23);
        imem[19] = enc(4'd8, 5, 5, 1);
        imem[20] = enc(4'd4, 3, 0, 24);
        imem[21] = enc(4'd9, 9, 0, 3);
        imem[22] = enc(4'd4, 9, 0, 25);
        imem[23] = enc(4'd2, 10, 0, 27);
        imem[24] = enc(4'd6, 10, 10, 0);
        imem[25] = enc(4'd4, 3, 0, 26);
        imem[26] = enc(4'd7, 0, 0, 0);
        imem[27] = enc(4'd4, 10, 0, 27);
        imem[28] = enc(4'd2, 11, 0, 3);
        imem[29] = enc(4'd2, 11, 11, -1);
        imem[30] = enc(4'd2, 12, 12, 1);
        imem[31] = enc(4'd8, 11, 0, 1);
        imem[32] = enc(4'd5, 0, 0, -4);
        imem[33] = enc(4'd4, 12, 0, 28);
        imem[34] = enc(4'hA, 3, 0, 5);
        imem[35] = enc(4'd4, 3, 0, 29);
        imem[36] = enc(4'd7, 0, 0, 0);
        imem[37] = enc(4'd4, 3, 0, 30);
    endtask

    task automatic run_to_stop();
        bit seen = 0;
        for (int c = 0; c < 500; c++) begin
            @(negedge clk);
            if (halted) begin
                seen = 1;
                break;
            end
        end
        if (!seen) begin
            n_tests++;
            n_fail++;
            $display("FAIL R9 watchdog: no stop, actual halted=%b expected=1", halted);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R9 global watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] stop_pc;
        init_mem();
        load_prog();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(" R1", {31'd0, halted}, 32'd0);
        chk(" R1", {16'd0, imem_addr}, 32'd0);
        rst_n = 1'b1;
        #1;
        chk(" R1", {16'd0, imem_addr}, 32'd0);

        run_to_stop();
        chk(" R9", {31'd0, halted}, 32'd1);
        for (int k = 0; k < NCHK; k++) begin
            chk(CHK_TAG[k], dmem[CHK_ADDR[k]], CHK_VAL[k]);
        end
        chk(" R5", stray_wr, 32'd0);
        stop_pc = imem_addr;
        chk(" R9", {16'd0, stop_pc}, 32'd36);
        repeat (5) @(negedge clk);
        chk(" R9", {16'd0, imem_addr}, {16'd0, stop_pc});
        chk(" R9", {31'd0, halted}, 32'd1);
        chk(" R9", stop_wr, 32'd0);

        // R1: reset leaves the stopped state and clears registers
        init_mem();
        rst_n = 1'b0;
        #1;
        chk(" R1", {31'd0, halted}, 32'd0);
        chk(" R1", {16'd0, imem_addr}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        run_to_stop();
        chk(" R1", dmem[28], 32'd3);
        chk(" R7", dmem[27], 32'd25);
        chk(" R2", dmem[16], 32'd4);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule